// File: doc/BRIEF.md
# Generator Address Marshal Buffer

This block sits beside one core and keeps a short list of the cache blocks written by stores that software has flagged as generator stores. These are the stores that produce data the next code segment will consume on another core. Each retiring store presents its physical address and a generator flag. Only flagged stores are recorded. Addresses are reduced to 64-byte block granularity, and a block that is already on the list is not added again.

When a marshal command arrives with a destination core number, the block sends every recorded block address, oldest first, as push requests on a valid/ready stream tagged with that destination. When the last request has been accepted, the list is empty and a one-cycle done pulse tells the core that the next segment may start. A marshal command on an empty list produces done at once, with no requests.

Marshaling is only a performance hint. When the list is full, new blocks are dropped and a sticky overflow flag records that some were lost.

Top module: `gen_marshal_buf`

## Requirements
- R1: While rst_ni is low and after it is released, the block shows no push request, no done pulse and no overflow, and it accepts a marshal command (msh_ready_o=1).
- R2: A store is recorded only when st_valid_i and st_gen_i are both 1. A store with st_gen_i=0 never leads to a push.
- R3: The block address is st_addr_i[ADDR_W-1:6]. A generator store whose block is already recorded adds no entry.
- R4: At most DEPTH (16) distinct blocks are held. A new block that arrives while the list is full is dropped and sets ovf_o. ovf_o then stays 1 until reset. A duplicate that arrives while the list is full does not set ovf_o.
- R5: A marshal command is taken in a cycle where msh_valid_i and msh_ready_o are both 1. msh_ready_o is 0 from the cycle after a non-empty command is taken until the drain ends, and commands offered in that time are ignored.
- R6: While draining, push_valid_o is 1. push_blk_o walks through the recorded blocks in the order they were first recorded, and advances by one entry on each cycle with push_valid_o and push_ready_i both 1. push_core_o equals the msh_core_i of the command that was taken.
- R7: While push_valid_o is 1 and push_ready_i is 0, push_valid_o, push_blk_o and push_core_o hold their values into the next cycle.
- R8: In the cycle after the last push handshake, done_o is 1 for one cycle, push_valid_o is 0 and the list is empty.
- R9: A marshal command taken while the list is empty makes done_o 1 in the next cycle, with no push request.
- R10: Generator stores that arrive in the same cycle as a taken marshal command, or during a drain, are not recorded.
- R11: After a drain, a new marshal command sends only blocks recorded after that drain.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| st_valid_i | input | 1 | Store retires this cycle |
| st_gen_i | input | 1 | Retiring store carries the generator flag |
| st_addr_i | input | ADDR_W (48) | Physical address of the store |
| msh_valid_i | input | 1 | Marshal command offered |
| msh_core_i | input | CORE_W (6) | Destination core of the command |
| msh_ready_o | output | 1 | Block can take a marshal command |
| push_valid_o | output | 1 | Push request valid |
| push_ready_i | input | 1 | Push request accepted |
| push_blk_o | output | ADDR_W-6 (42) | Block address to push |
| push_core_o | output | CORE_W (6) | Destination core of the push |
| done_o | output | 1 | One-cycle pulse: marshal finished |
| ovf_o | output | 1 | Sticky: a generator block was dropped |

## Verification
Several properties are checked on every cycle:
- the entry count stays within capacity, and at most one entry matches an incoming block;
- a dropped block leaves the count unchanged and the overflow flag stays set;
- a stalled push request holds steady;
- the done pulse follows both the final handshake and an empty command.

Other behaviours only the bench scenarios can show, because they concern which blocks reach the stream and in what order. These are:
- block-level deduplication and the filtering of ordinary stores;
- the order of insertion;
- the loss of stores offered during or alongside a drain;
- the sixteen-plus-one overflow case.

// File: rtl/gmb_pkg.sv
package gmb_pkg;
  typedef enum logic {GMB_IDLE, GMB_DRAIN} gmb_state_e;
endpackage

// File: rtl/gmb_entry_store.sv
module gmb_entry_store #(
  parameter int DEPTH = 16,
  parameter int BLK_W = 42,
  localparam int CNT_W = $clog2(DEPTH + 1),
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ins_i,
  input  logic [BLK_W-1:0] ins_blk_i,
  input  logic             clr_i,
  input  logic [IDX_W-1:0] rd_idx_i,
  output logic [BLK_W-1:0] rd_blk_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic             ovf_o
);
  logic [BLK_W-1:0] mem_q [DEPTH];
  logic [CNT_W-1:0] cnt_q;
  logic [DEPTH-1:0] hit;
  logic             full, do_wr, do_ovf, ovf_q;

  for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
    assign hit[g] = (CNT_W'(g) < cnt_q) && (mem_q[g] == ins_blk_i);
  end

  assign full   = (cnt_q == CNT_W'(DEPTH));
  assign do_wr  = ins_i && !(|hit) && !full;
  assign do_ovf = ins_i && !(|hit) && full;

  always_ff @(posedge clk_i) begin
    if (do_wr) mem_q[cnt_q[IDX_W-1:0]] <= ins_blk_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      ovf_q <= 1'b0;
    end else begin
      if (clr_i)      cnt_q <= '0;
      else if (do_wr) cnt_q <= cnt_q + CNT_W'(1);
      if (do_ovf)     ovf_q <= 1'b1;
    end
  end

  assign rd_blk_o = mem_q[rd_idx_i];
  assign cnt_o    = cnt_q;
  assign ovf_o    = ovf_q;

  p_cnt_bound_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_W'(DEPTH));
  p_unique_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ins_i |-> $onehot0(hit));
  p_dup_no_grow_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ins_i && (|hit) && !clr_i) |=> $stable(cnt_q));
  p_full_drop_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ins_i && full && !(|hit) && !clr_i) |=> (cnt_q == CNT_W'(DEPTH)) && ovf_q);
  p_ovf_sticky_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_q |=> ovf_q);
endmodule

// File: rtl/gmb_drain_ctl.sv
module gmb_drain_ctl
  import gmb_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int CORE_W = 6,
  localparam int CNT_W = $clog2(DEPTH + 1),
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              msh_valid_i,
  input  logic [CORE_W-1:0] msh_core_i,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic              push_ready_i,
  output logic              msh_ready_o,
  output logic              push_valid_o,
  output logic [CORE_W-1:0] push_core_o,
  output logic [IDX_W-1:0]  rd_idx_o,
  output logic              clr_o,
  output logic              done_o
);
  gmb_state_e        state_q;
  logic [CORE_W-1:0] core_q;
  logic [IDX_W-1:0]  idx_q;
  logic              done_q, take, hs, last;

  assign msh_ready_o  = (state_q == GMB_IDLE);
  assign push_valid_o = (state_q == GMB_DRAIN);
  assign take  = msh_valid_i && msh_ready_o;
  assign hs    = push_valid_o && push_ready_i;
  assign last  = (CNT_W'(idx_q) + CNT_W'(1)) == cnt_i;
  assign clr_o = hs && last;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= GMB_IDLE;
      core_q  <= '0;
      idx_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (state_q)
        GMB_IDLE: if (take) begin
          if (cnt_i == '0) done_q <= 1'b1;
          else begin
            state_q <= GMB_DRAIN;
            core_q  <= msh_core_i;
            idx_q   <= '0;
          end
        end
        GMB_DRAIN: if (hs) begin
          if (last) begin
            state_q <= GMB_IDLE;
            done_q  <= 1'b1;
          end else idx_q <= idx_q + IDX_W'(1);
        end
        default: state_q <= GMB_IDLE;
      endcase
    end
  end

  assign push_core_o = core_q;
  assign rd_idx_o    = idx_q;
  assign done_o      = done_q;

  p_done_after_last_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_o |=> done_o && msh_ready_o && !push_valid_o);
  p_empty_done_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take && cnt_i == '0) |=> done_o && !push_valid_o);
  p_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_valid_o && !push_ready_i) |=> push_valid_o && $stable(rd_idx_o) && $stable(push_core_o));
endmodule

// File: rtl/gen_marshal_buf.sv
module gen_marshal_buf #(
  parameter int ADDR_W  = 48,
  parameter int BLK_OFF = 6,
  parameter int DEPTH   = 16,
  parameter int CORE_W  = 6,
  localparam int BLK_W  = ADDR_W - BLK_OFF,
  localparam int CNT_W  = $clog2(DEPTH + 1),
  localparam int IDX_W  = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              st_valid_i,
  input  logic              st_gen_i,
  input  logic [ADDR_W-1:0] st_addr_i,
  input  logic              msh_valid_i,
  input  logic [CORE_W-1:0] msh_core_i,
  output logic              msh_ready_o,
  output logic              push_valid_o,
  input  logic              push_ready_i,
  output logic [BLK_W-1:0]  push_blk_o,
  output logic [CORE_W-1:0] push_core_o,
  output logic              done_o,
  output logic              ovf_o
);
  logic             ins, clr;
  logic [IDX_W-1:0] rd_idx;
  logic [CNT_W-1:0] cnt;

  // record only while idle and no command is being taken
  assign ins = st_valid_i && st_gen_i && msh_ready_o && !msh_valid_i;

  gmb_entry_store #(.DEPTH(DEPTH), .BLK_W(BLK_W)) u_store (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .ins_i     (ins),
    .ins_blk_i (st_addr_i[ADDR_W-1:BLK_OFF]),
    .clr_i     (clr),
    .rd_idx_i  (rd_idx),
    .rd_blk_o  (push_blk_o),
    .cnt_o     (cnt),
    .ovf_o     (ovf_o)
  );

  gmb_drain_ctl #(.DEPTH(DEPTH), .CORE_W(CORE_W)) u_ctl (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .msh_valid_i  (msh_valid_i),
    .msh_core_i   (msh_core_i),
    .cnt_i        (cnt),
    .push_ready_i (push_ready_i),
    .msh_ready_o  (msh_ready_o),
    .push_valid_o (push_valid_o),
    .push_core_o  (push_core_o),
    .rd_idx_o     (rd_idx),
    .clr_o        (clr),
    .done_o       (done_o)
  );

  p_push_stable_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_valid_o && !push_ready_i) |=> $stable(push_blk_o));
  p_drain_frozen_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_valid_o && !push_ready_i) |=> $stable(cnt));
endmodule

// File: tb/sim_gen_marshal_buf.sv
module sim_gen_marshal_buf;
  localparam int ADDR_W = 48;
  localparam int CORE_W = 6;
  localparam int BLK_W  = 42;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic              rst_n = 1'b0;
  logic              st_valid = 0, st_gen = 0, msh_valid = 0, push_ready = 0;
  logic [ADDR_W-1:0] st_addr = '0;
  logic [CORE_W-1:0] msh_core = '0;
  logic              msh_ready, push_valid, done, ovf;
  logic [BLK_W-1:0]  push_blk;
  logic [CORE_W-1:0] push_core;

  gen_marshal_buf u0 (
    .clk_i(clk), .rst_ni(rst_n), .st_valid_i(st_valid), .st_gen_i(st_gen),
    .st_addr_i(st_addr), .msh_valid_i(msh_valid), .msh_core_i(msh_core),
    .msh_ready_o(msh_ready), .push_valid_o(push_valid), .push_ready_i(push_ready),
    .push_blk_o(push_blk), .push_core_o(push_core), .done_o(done), .ovf_o(ovf)
  );

  int n_run = 0, n_fail = 0, cyc = 0;
  logic [BLK_W-1:0] exp_q[$];

  // [49]=generator flag, [48]=expected new entry, [47:0]=address
  localparam logic [49:0] VEC [10] = '{
    {1'b1, 1'b1, 48'h0000_0000_1000},
    {1'b0, 1'b0, 48'h0000_0000_2000},
    {1'b1, 1'b0, 48'h0000_0000_1008},
    {1'b1, 1'b1, 48'h0000_0000_2040},
    {1'b1, 1'b0, 48'h0000_0000_103F},
    {1'b1, 1'b1, 48'h0000_0000_1040},
    {1'b0, 1'b0, 48'h0000_0000_3000},
    {1'b1, 1'b1, 48'hFFFF_FFFF_FFC0},
    {1'b1, 1'b1, 48'h0000_0000_2000},
    {1'b1, 1'b0, 48'h0000_0000_2044}
  };

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic store(input logic gen, input logic [ADDR_W-1:0] a);
    st_valid = 1; st_gen = gen; st_addr = a;
    @(negedge clk);
    st_valid = 0; st_gen = 0;
  endtask

  // mode 0: plain, 1: store and command offered mid-drain, 2: store alongside command
  task automatic drain(input logic [CORE_W-1:0] core, input bit stall, input int mode);
    int n, k, g;
    bit stalled;
    logic [BLK_W-1:0] prev;
    n = exp_q.size(); k = 0; g = 0; stalled = 0; prev = '0;
    chk("R5 ready before command", msh_ready, 1);
    msh_valid = 1; msh_core = core;
    if (mode == 2) begin st_valid = 1; st_gen = 1; st_addr = 48'h0000_00AB_C000; end
    @(negedge clk);
    msh_valid = 0; st_valid = 0; st_gen = 0;
    if (n == 0) begin
      chk("R9 done on empty command", done, 1);
      chk("R9 no push on empty command", push_valid, 0);
      @(negedge clk);
      chk("R8 done is one pulse", done, 0);
      return;
    end
    while (k < n) begin
      chk("R6 push valid while draining", push_valid, 1);
      chk("R5 not ready while draining", msh_ready, 0);
      if (stalled) chk("R7 block held while stalled", push_blk, prev);
      push_ready = stall ? (g % 2 == 1) : 1'b1;
      if (mode == 1 && g == 1) begin
        st_valid = 1; st_gen = 1; st_addr = 48'h0000_00DE_F000;
        msh_valid = 1; msh_core = core + 6'd1;
      end
      if (push_ready) begin
        chk("R6 block order", push_blk, exp_q[k]);
        chk("R6 destination core", push_core, core);
        k++; stalled = 0;
      end else begin
        stalled = 1; prev = push_blk;
      end
      g++;
      @(negedge clk);
      push_ready = 0; st_valid = 0; st_gen = 0; msh_valid = 0;
    end
    chk("R8 done after last push", done, 1);
    chk("R8 no push after last", push_valid, 0);
    @(negedge clk);
    chk("R8 done is one pulse", done, 0);
    exp_q.delete();
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000) begin
      n_fail++;
      $display("FAIL R6 watchdog act=hung exp=finished");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 push_valid in reset", push_valid, 0);
    chk("R1 done in reset", done, 0);
    chk("R1 ovf in reset", ovf, 0);
    rst_n = 1;
    @(negedge clk);
    chk("R1 ready after reset", msh_ready, 1);
    chk("R1 push_valid after reset", push_valid, 0);

    // R2 R3: table walk, generator filter and block dedup
    for (int i = 0; i < 10; i++) begin
      store(VEC[i][49], VEC[i][47:0]);
      if (VEC[i][48]) exp_q.push_back(VEC[i][47:6]);
    end
    drain(6'd5, 1'b1, 1);
    // R10 R11: the store poked mid-drain must not appear
    drain(6'd9, 1'b0, 0);
    chk("R4 no overflow yet", ovf, 0);

    // R10: store alongside an accepted command is lost
    store(1'b1, 48'h0000_0000_7000);
    exp_q.push_back(48'h0000_0000_7000 >> 6);
    drain(6'd33, 1'b0, 2);
    drain(6'd2, 1'b0, 0);

    // R2: ordinary store alone gives no push
    store(1'b0, 48'h0000_0000_5000);
    drain(6'd3, 1'b0, 0);

    // R4: fill, duplicate when full, then overflow
    for (int i = 0; i < 16; i++) begin
      store(1'b1, 48'h0000_0001_0000 + 48'(i * 64));
      exp_q.push_back((48'h0000_0001_0000 + 48'(i * 64)) >> 6);
    end
    chk("R4 full without overflow", ovf, 0);
    store(1'b1, 48'h0000_0001_0005);
    chk("R4 duplicate when full", ovf, 0);
    store(1'b1, 48'h0000_0009_0000);
    chk("R4 overflow on new block", ovf, 1);
    drain(6'd63, 1'b1, 0);
    chk("R4 overflow sticky", ovf, 1);
    drain(6'd1, 1'b0, 0);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule